// File: doc/BRIEF.md
# Queued Gather/Scatter Block Mover

This block moves data between a local scratchpad and main memory on behalf of software. Software posts transfer commands into a small queue. The engine takes them one at a time and breaks each into 32-byte memory beats. It keeps up to sixteen of those beats in flight, each with its own tag. Memory may answer in any order. The engine routes every answer to the scratchpad row it recorded for that tag.

A command names a direction, an addressing pattern, a memory base, a scratchpad base, an element count, an element length in beats and a stride word. The three patterns are as follows:
- Contiguous: one run of beats.
- Fixed-gap: elements of equal length, each placed a programmable byte distance after the previous one.
- Table-driven: each element's offset is read from a list held in the scratchpad.

A fetch copies memory into the scratchpad. A store copies scratchpad rows out to memory. Each command raises a one-cycle completion pulse carrying its sequence number, and only after every beat it issued has been answered.

Top module: `dma_engine`

## Requirements
- R1: Commands are accepted while `cmdReady` is high, up to QDEPTH waiting. They are executed strictly in acceptance order. Each raises exactly one `doneValid` pulse whose `doneId` equals its acceptance position counted from zero after reset, modulo 2^IDW. `cmdReady` is low while the queue is full.
- R2: In contiguous mode (`cmdMode` 0, also 3), a command issues count×beats requests. Request k has address memBase + 32·k, and beat k uses scratchpad row lsBase + k.
- R3: In fixed-gap mode (`cmdMode` 1), beat b of element e has address memBase + e·stride + 32·b, where stride is the byte value on `cmdStride`. Scratchpad rows stay consecutive from lsBase.
- R4: In table-driven mode (`cmdMode` 2), element e starts at memBase + 32·X. X is the low 16 bits of scratchpad row (cmdStride low LSAW bits) + e, read before that element's first beat.
- R5: For a fetch (`cmdGet`=1, `memReqWrite`=0), the data of each response is written to the scratchpad row of the beat that used that tag, whatever the order of the responses.
- R6: For a store (`cmdGet`=0), each request has `memReqWrite`=1 and carries in `memReqData` the contents of its scratchpad row.
- R7: No tag is reissued while it is outstanding. At most 16 requests are unanswered at once, and issue stalls while all tags are in use.
- R8: While `memReqValid` is high and `memReqReady` is low, the request keeps its address and direction into the next cycle.
- R9: `doneValid` rises only once no request is unanswered, and lasts one cycle.
- R10: A command with element count 0 completes without any memory request.
- R11: A response write to the scratchpad is never delayed. Index and store reads wait for a cycle with no such write, so no response data is lost in table-driven fetches. An element length of 0 means 16 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Queue has room |
| cmdGet | input | 1 | 1 = memory to scratchpad, 0 = scratchpad to memory |
| cmdMode | input | 2 | 0/3 contiguous, 1 fixed-gap, 2 table-driven |
| cmdMemBase | input | AW | Memory byte base |
| cmdLsBase | input | LSAW | First scratchpad row |
| cmdCount | input | CW | Element count |
| cmdElemBeats | input | EW | Beats per element (0 = 16) |
| cmdStride | input | AW | Byte gap, or index-list row in table mode |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts request |
| memReqWrite | output | 1 | Request is a store |
| memReqAddr | output | AW | Request byte address |
| memReqTag | output | TW | Request tag |
| memReqData | output | DW | Store data |
| memRspValid | input | 1 | Response valid |
| memRspTag | input | TW | Tag being answered |
| memRspData | input | DW | Fetched data |
| lsEn | output | 1 | Scratchpad access |
| lsWe | output | 1 | Scratchpad write |
| lsAddr | output | LSAW | Scratchpad row |
| lsWdata | output | DW | Scratchpad write data |
| lsRdata | input | DW | Scratchpad read data, one cycle after a read |
| doneValid | output | 1 | Command completed |
| doneId | output | IDW | Sequence number of completed command |

## Verification
Suppose the tag table loses track of a slot. The next fetch response then lands in the wrong scratchpad row, or the tag is handed out twice. A swapped row shows up in the row contents as soon as the command completes. A reissued tag trips the shadow-tag property in the same cycle. Address generator faults show in the request address on the very beat they affect. A drain fault shows up as a completion pulse while responses are still held back. The bench holds responses on purpose to expose this.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int BEAT_SHIFT = 5;

  typedef enum logic [1:0] {
    MODE_SEQ    = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_SEQ2   = 2'd3
  } xferModeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_IDXRD,
    ST_IDXCAP,
    ST_DATRD,
    ST_DATCAP,
    ST_ISSUE,
    ST_DRAIN
  } ctrlStateT;

  typedef struct packed {
    logic loadCmd;
    logic readIndex;
    logic captureIndex;
    logic readData;
    logic captureData;
    logic issueBeat;
  } dpStrobeT;

  typedef struct packed {
    logic countZero;
    logic isGet;
    logic isIndexed;
    logic lastElemBeat;
    logic lastBeat;
    logic tagAvail;
    logic lsBusy;
    logic allIdle;
  } dpStatusT;

endpackage

// File: rtl/dma_cmd_queue.sv
module dma_cmd_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int IDW   = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pushValid,
  output logic           pushReady,
  input  logic [W-1:0]   pushData,
  output logic           popValid,
  input  logic           pop,
  output logic [W-1:0]   popData,
  output logic [IDW-1:0] popId
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W+IDW-1:0] slots [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [PW:0]      fill;
  logic [IDW-1:0]   nextId;
  logic             doPush, doPop;

  assign pushReady = (fill != (PW+1)'(DEPTH));
  assign popValid  = (fill != '0);
  assign doPush    = pushValid && pushReady;
  assign doPop     = pop && popValid;
  assign {popData, popId} = slots[rdPtr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= {pushData, nextId};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      fill   <= '0;
      nextId <= '0;
    end else begin
      if (doPush) begin
        wrPtr  <= bump(wrPtr);
        nextId <= nextId + IDW'(1);
      end
      if (doPop) rdPtr <= bump(rdPtr);
      fill <= fill + (PW+1)'(doPush) - (PW+1)'(doPop);
    end
  end
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LSAW = 10,
  parameter int CW   = 8,
  parameter int EW   = 4,
  parameter int DW   = 256,
  parameter int TAGS = 16,
  parameter int TW   = 4,
  parameter int IXW  = 16,
  parameter int IDW  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobeT        st,
  output dpStatusT        status,
  input  logic            headGet,
  input  logic [1:0]      headMode,
  input  logic [AW-1:0]   headMemBase,
  input  logic [LSAW-1:0] headLsBase,
  input  logic [CW-1:0]   headCount,
  input  logic [EW-1:0]   headElemBeats,
  input  logic [AW-1:0]   headStride,
  input  logic [IDW-1:0]  headId,
  output logic            memReqWrite,
  output logic [AW-1:0]   memReqAddr,
  output logic [TW-1:0]   memReqTag,
  output logic [DW-1:0]   memReqData,
  input  logic            memRspValid,
  input  logic [TW-1:0]   memRspTag,
  input  logic [DW-1:0]   memRspData,
  output logic            lsEn,
  output logic            lsWe,
  output logic [LSAW-1:0] lsAddr,
  output logic [DW-1:0]   lsWdata,
  input  logic [DW-1:0]   lsRdata,
  output logic [IDW-1:0]  doneId
);
  logic            curGet;
  xferModeT        curMode;
  logic [AW-1:0]   memBase, stride, elemAddr, beatAddr;
  logic [LSAW-1:0] lsPtr, idxRow;
  logic [CW-1:0]   count, elemIdx;
  logic [EW-1:0]   elemBeats, beatIdx;
  logic [DW-1:0]   reqData;

  logic [TAGS-1:0] tagBusy;
  logic [LSAW-1:0] tagRow [TAGS];
  logic [TAGS-1:0] tagGet;
  logic [TW-1:0]   freeTag;

  assign beatAddr = elemAddr + (AW'(beatIdx) << BEAT_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curGet <= 1'b0;
      curMode <= MODE_SEQ;
      memBase <= '0;
      stride <= '0;
      lsPtr <= '0;
      idxRow <= '0;
      count <= '0;
      elemBeats <= '0;
      elemIdx <= '0;
      beatIdx <= '0;
      elemAddr <= '0;
      doneId <= '0;
    end else if (st.loadCmd) begin
      curGet <= headGet;
      curMode <= xferModeT'(headMode);
      memBase <= headMemBase;
      stride <= headStride;
      lsPtr <= headLsBase;
      idxRow <= headStride[LSAW-1:0];
      count <= headCount;
      elemBeats <= headElemBeats;
      elemIdx <= '0;
      beatIdx <= '0;
      elemAddr <= headMemBase;
      doneId <= headId;
    end else if (st.captureIndex) begin
      elemAddr <= memBase + (AW'(lsRdata[IXW-1:0]) << BEAT_SHIFT);
      idxRow <= idxRow + LSAW'(1);
    end else if (st.issueBeat) begin
      lsPtr <= lsPtr + LSAW'(1);
      if (status.lastElemBeat) begin
        beatIdx <= '0;
        elemIdx <= elemIdx + CW'(1);
        elemAddr <= (curMode == MODE_STRIDE) ? elemAddr + stride
                                             : beatAddr + AW'(32);
      end else begin
        beatIdx <= beatIdx + EW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.captureData) reqData <= lsRdata;
  end

  always_comb begin
    freeTag = '0;
    for (int i = TAGS-1; i >= 0; i--) begin
      if (!tagBusy[i]) freeTag = TW'(i);
    end
  end

  for (genvar g = 0; g < TAGS; g++) begin : gTag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagBusy[g] <= 1'b0;
        tagGet[g] <= 1'b0;
        tagRow[g] <= '0;
      end else if (st.issueBeat && freeTag == TW'(g)) begin
        tagBusy[g] <= 1'b1;
        tagGet[g] <= curGet;
        tagRow[g] <= lsPtr;
      end else if (memRspValid && memRspTag == TW'(g)) begin
        tagBusy[g] <= 1'b0;
      end
    end
  end

  assign status.countZero    = (count == '0);
  assign status.isGet        = curGet;
  assign status.isIndexed    = (curMode == MODE_INDEX);
  assign status.lastElemBeat = (beatIdx == elemBeats - EW'(1));
  assign status.lastBeat     = status.lastElemBeat && (elemIdx == count - CW'(1));
  assign status.tagAvail     = ~&tagBusy;
  assign status.lsBusy       = memRspValid && tagGet[memRspTag];
  assign status.allIdle      = (tagBusy == '0);

  assign memReqWrite = !curGet;
  assign memReqAddr  = beatAddr;
  assign memReqTag   = freeTag;
  assign memReqData  = reqData;

  assign lsEn    = status.lsBusy || st.readIndex || st.readData;
  assign lsWe    = status.lsBusy;
  assign lsWdata = memRspData;
  assign lsAddr  = status.lsBusy ? tagRow[memRspTag] :
                   st.readIndex  ? idxRow : lsPtr;
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     queueValid,
  output logic     queuePop,
  input  dpStatusT status,
  output dpStrobeT st,
  output logic     memReqValid,
  input  logic     memReqReady,
  output logic     doneValid
);
  ctrlStateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    st          = '0;
    queuePop    = 1'b0;
    memReqValid = 1'b0;
    doneValid   = 1'b0;
    unique case (state)
      ST_IDLE: if (queueValid) begin
        queuePop   = 1'b1;
        st.loadCmd = 1'b1;
        nextState  = ST_START;
      end
      ST_START: begin
        if (status.countZero)      nextState = ST_DRAIN;
        else if (status.isIndexed) nextState = ST_IDXRD;
        else if (!status.isGet)    nextState = ST_DATRD;
        else                       nextState = ST_ISSUE;
      end
      ST_IDXRD: if (!status.lsBusy) begin
        st.readIndex = 1'b1;
        nextState    = ST_IDXCAP;
      end
      ST_IDXCAP: begin
        st.captureIndex = 1'b1;
        nextState       = status.isGet ? ST_ISSUE : ST_DATRD;
      end
      ST_DATRD: if (!status.lsBusy) begin
        st.readData = 1'b1;
        nextState   = ST_DATCAP;
      end
      ST_DATCAP: begin
        st.captureData = 1'b1;
        nextState      = ST_ISSUE;
      end
      ST_ISSUE: begin
        memReqValid = status.tagAvail;
        if (status.tagAvail && memReqReady) begin
          st.issueBeat = 1'b1;
          if (status.lastBeat)                             nextState = ST_DRAIN;
          else if (status.lastElemBeat && status.isIndexed) nextState = ST_IDXRD;
          else if (!status.isGet)                          nextState = ST_DATRD;
        end
      end
      ST_DRAIN: if (status.allIdle) begin
        doneValid = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LSAW   = 10,
  parameter int CW     = 8,
  parameter int EW     = 4,
  parameter int DW     = 256,
  parameter int TAGS   = 16,
  parameter int QDEPTH = 4,
  parameter int IDW    = 4,
  parameter int IXW    = 16,
  localparam int TW    = $clog2(TAGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  output logic            cmdReady,
  input  logic            cmdGet,
  input  logic [1:0]      cmdMode,
  input  logic [AW-1:0]   cmdMemBase,
  input  logic [LSAW-1:0] cmdLsBase,
  input  logic [CW-1:0]   cmdCount,
  input  logic [EW-1:0]   cmdElemBeats,
  input  logic [AW-1:0]   cmdStride,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic            memReqWrite,
  output logic [AW-1:0]   memReqAddr,
  output logic [TW-1:0]   memReqTag,
  output logic [DW-1:0]   memReqData,
  input  logic            memRspValid,
  input  logic [TW-1:0]   memRspTag,
  input  logic [DW-1:0]   memRspData,
  output logic            lsEn,
  output logic            lsWe,
  output logic [LSAW-1:0] lsAddr,
  output logic [DW-1:0]   lsWdata,
  input  logic [DW-1:0]   lsRdata,
  output logic            doneValid,
  output logic [IDW-1:0]  doneId
);
  localparam int CMDW = 1 + 2 + AW + LSAW + CW + EW + AW;

  logic            queueValid, queuePop;
  logic [CMDW-1:0] headWord;
  logic [IDW-1:0]  headId;
  logic            headGet;
  logic [1:0]      headMode;
  logic [AW-1:0]   headMemBase, headStride;
  logic [LSAW-1:0] headLsBase;
  logic [CW-1:0]   headCount;
  logic [EW-1:0]   headElemBeats;
  dpStrobeT        strobes;
  dpStatusT        status;

  assign {headGet, headMode, headMemBase, headLsBase, headCount,
          headElemBeats, headStride} = headWord;

  dma_cmd_queue #(.W(CMDW), .DEPTH(QDEPTH), .IDW(IDW)) uQueue (
    .clk(clk), .rstN(rstN),
    .pushValid(cmdValid), .pushReady(cmdReady),
    .pushData({cmdGet, cmdMode, cmdMemBase, cmdLsBase, cmdCount,
               cmdElemBeats, cmdStride}),
    .popValid(queueValid), .pop(queuePop),
    .popData(headWord), .popId(headId)
  );

  dma_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .queueValid(queueValid), .queuePop(queuePop),
    .status(status), .st(strobes),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .doneValid(doneValid)
  );

  dma_datapath #(
    .AW(AW), .LSAW(LSAW), .CW(CW), .EW(EW), .DW(DW),
    .TAGS(TAGS), .TW(TW), .IXW(IXW), .IDW(IDW)
  ) uData (
    .clk(clk), .rstN(rstN), .st(strobes), .status(status),
    .headGet(headGet), .headMode(headMode), .headMemBase(headMemBase),
    .headLsBase(headLsBase), .headCount(headCount),
    .headElemBeats(headElemBeats), .headStride(headStride), .headId(headId),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqTag(memReqTag),
    .memReqData(memReqData),
    .memRspValid(memRspValid), .memRspTag(memRspTag), .memRspData(memRspData),
    .lsEn(lsEn), .lsWe(lsWe), .lsAddr(lsAddr), .lsWdata(lsWdata),
    .lsRdata(lsRdata), .doneId(doneId)
  );
endmodule

// File: rtl/dma_engine_checker.sv
module dma_engine_checker #(
  parameter int AW   = 32,
  parameter int TAGS = 16,
  parameter int TW   = 4,
  parameter int IDW  = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic           memReqValid,
  input logic           memReqReady,
  input logic           memReqWrite,
  input logic [AW-1:0]  memReqAddr,
  input logic [TW-1:0]  memReqTag,
  input logic           memRspValid,
  input logic [TW-1:0]  memRspTag,
  input logic           doneValid,
  input logic [IDW-1:0] doneId
);
  logic [TAGS-1:0] shadowBusy;
  logic [IDW-1:0]  expectId;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowBusy <= '0;
      expectId   <= '0;
    end else begin
      if (memReqValid && memReqReady) shadowBusy[memReqTag] <= 1'b1;
      if (memRspValid) shadowBusy[memRspTag] <= 1'b0;
      if (doneValid) expectId <= expectId + IDW'(1);
    end
  end

  assert_tag_free_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !shadowBusy[memReqTag]);

  assert_rsp_known_R5: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> shadowBusy[memRspTag]);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

  assert_done_drained_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (shadowBusy == '0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_done_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneId == expectId));
endmodule

bind dma_engine dma_engine_checker #(
  .AW(AW), .TAGS(TAGS), .TW(TW), .IDW(IDW)
) uChecker (.*);

// File: tb/sim_dma_engine.sv
module sim_dma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, LSAW = 6, CW = 8, EW = 4, DW = 256, TW = 4, IDW = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, cmdReady, cmdGet = 1'b0;
  logic [1:0] cmdMode = '0;
  logic [AW-1:0] cmdMemBase = '0, cmdStride = '0;
  logic [LSAW-1:0] cmdLsBase = '0;
  logic [CW-1:0] cmdCount = '0;
  logic [EW-1:0] cmdElemBeats = '0;
  logic memReqValid, memReqReady = 1'b1, memReqWrite;
  logic [AW-1:0] memReqAddr;
  logic [TW-1:0] memReqTag;
  logic [DW-1:0] memReqData;
  logic memRspValid = 1'b0;
  logic [TW-1:0] memRspTag = '0;
  logic [DW-1:0] memRspData = '0;
  logic lsEn, lsWe;
  logic [LSAW-1:0] lsAddr;
  logic [DW-1:0] lsWdata, lsRdata;
  logic doneValid;
  logic [IDW-1:0] doneId;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_engine #(.AW(AW), .LSAW(LSAW), .CW(CW), .EW(EW), .DW(DW), .IDW(IDW)) u0 (.*);

  int checks = 0, fails = 0;
  logic [DW-1:0] lsMem [0:63];
  logic readyHold = 1'b0, rspHold = 1'b0, rspLifo = 1'b0;
  int reqN = 0, pendN = 0, doneN = 0;
  logic [AW-1:0] reqAddr [0:63];
  logic          reqWr   [0:63];
  logic [DW-1:0] reqData [0:63];
  logic [TW-1:0] reqTag  [0:63];
  logic [AW-1:0] pendAddr [0:31];
  logic          pendWr   [0:31];
  logic [TW-1:0] pendTag  [0:31];
  logic [IDW-1:0] doneLog [0:31];

  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] a);
    return {8{a ^ 32'h5A00_0000}};
  endfunction

  always @(posedge clk) begin
    if (lsEn) begin
      if (lsWe) lsMem[lsAddr] <= lsWdata;
      else      lsRdata <= lsMem[lsAddr];
    end
  end

  always @(negedge clk) begin
    memReqReady = !readyHold;
    if (rstN && doneValid) begin
      doneLog[doneN] = doneId;
      doneN++;
    end
    memRspValid = 1'b0;
    if (!rspHold && pendN > 0) begin
      int pick;
      pick = rspLifo ? pendN - 1 : 0;
      memRspValid = 1'b1;
      memRspTag   = pendTag[pick];
      memRspData  = pendWr[pick] ? '0 : memWord(pendAddr[pick]);
      for (int i = pick; i < pendN - 1; i++) begin
        pendTag[i] = pendTag[i+1];
        pendAddr[i] = pendAddr[i+1];
        pendWr[i] = pendWr[i+1];
      end
      pendN--;
    end
    if (rstN && memReqValid && memReqReady) begin
      reqAddr[reqN] = memReqAddr;
      reqWr[reqN]   = memReqWrite;
      reqData[reqN] = memReqData;
      reqTag[reqN]  = memReqTag;
      reqN++;
      pendTag[pendN] = memReqTag;
      pendAddr[pendN] = memReqAddr;
      pendWr[pendN] = memReqWrite;
      pendN++;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushCmd(input logic get, input logic [1:0] mode,
                         input logic [AW-1:0] mem, input logic [LSAW-1:0] ls,
                         input logic [CW-1:0] cnt, input logic [EW-1:0] beats,
                         input logic [AW-1:0] strd);
    @(negedge clk);
    cmdGet = get; cmdMode = mode; cmdMemBase = mem; cmdLsBase = ls;
    cmdCount = cnt; cmdElemBeats = beats; cmdStride = strd;
    cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitDone(input int n);
    int t = 0;
    while (doneN < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
  endtask

  task automatic setFlags(input logic rh, input logic rsh, input logic lifo);
    @(posedge clk);
    readyHold = rh; rspHold = rsh; rspLifo = lifo;
  endtask

  task automatic testReset();
    check(cmdReady == 1'b1, "R1 reset cmdReady", DW'(cmdReady), 1);
    check(memReqValid == 1'b0, "R7 reset memReqValid", DW'(memReqValid), 0);
    check(doneValid == 1'b0, "R9 reset doneValid", DW'(doneValid), 0);
  endtask

  task automatic testSeqGet();
    reqN = 0;
    pushCmd(1'b1, 2'd0, 32'h1000, 6'd4, 8'd3, 4'd2, 32'h0);
    waitDone(1);
    check(reqN == 6, "R2 seq beat count", DW'(reqN), 6);
    for (int k = 0; k < 6; k++) begin
      check(reqAddr[k] == 32'h1000 + 32*k && !reqWr[k], "R2 seq address",
            DW'(reqAddr[k]), DW'(32'h1000 + 32*k));
      check(lsMem[4+k] == memWord(32'h1000 + 32*k), "R5 seq row data",
            lsMem[4+k], memWord(32'h1000 + 32*k));
    end
    check(doneLog[0] == 0, "R1 first doneId", DW'(doneLog[0]), 0);
  endtask

  task automatic testTagsReverse();
    logic [15:0] mask = '0;
    reqN = 0;
    setFlags(1'b0, 1'b1, 1'b1);
    pushCmd(1'b1, 2'd3, 32'h4000, 6'd16, 8'd20, 4'd1, 32'h0);
    repeat (60) @(negedge clk);
    check(reqN == 16, "R7 outstanding cap", DW'(reqN), 16);
    check(doneN == 1, "R9 no done while pending", DW'(doneN), 1);
    for (int k = 0; k < 16; k++) mask[reqTag[k]] = 1'b1;
    check(mask == 16'hFFFF, "R7 distinct tags", DW'(mask), DW'(16'hFFFF));
    setFlags(1'b0, 1'b0, 1'b1);
    waitDone(2);
    check(reqN == 20, "R2 long seq count", DW'(reqN), 20);
    for (int k = 0; k < 20; k++)
      check(lsMem[16+k] == memWord(32'h4000 + 32*k), "R5 out-of-order row",
            lsMem[16+k], memWord(32'h4000 + 32*k));
    setFlags(1'b0, 1'b0, 1'b0);
  endtask

  task automatic testStrided();
    reqN = 0;
    setFlags(1'b1, 1'b0, 1'b0);
    pushCmd(1'b1, 2'd1, 32'h8000, 6'd40, 8'd3, 4'd2, 32'h100);
    repeat (10) @(negedge clk);
    check(reqN == 0 && memReqValid, "R8 stalled request held",
          DW'(reqN), 0);
    check(memReqAddr == 32'h8000, "R8 held address", DW'(memReqAddr), DW'(32'h8000));
    setFlags(1'b0, 1'b0, 1'b0);
    waitDone(3);
    for (int e = 0; e < 3; e++)
      for (int b = 0; b < 2; b++) begin
        int k = e*2 + b;
        logic [AW-1:0] a = 32'h8000 + e*32'h100 + 32*b;
        check(reqAddr[k] == a, "R3 strided address", DW'(reqAddr[k]), DW'(a));
        check(lsMem[40+k] == memWord(a), "R3 strided row", lsMem[40+k], memWord(a));
      end
  endtask

  task automatic testIndexed();
    logic [AW-1:0] exp [3];
    reqN = 0;
    @(negedge clk);
    lsMem[50] = DW'(7); lsMem[51] = DW'(2); lsMem[52] = DW'(30);
    exp[0] = 32'h100E0; exp[1] = 32'h10040; exp[2] = 32'h103C0;
    pushCmd(1'b1, 2'd2, 32'h10000, 6'd0, 8'd3, 4'd1, 32'd50);
    waitDone(4);
    check(reqN == 3, "R4 indexed count", DW'(reqN), 3);
    for (int k = 0; k < 3; k++) begin
      check(reqAddr[k] == exp[k], "R4 indexed address", DW'(reqAddr[k]), DW'(exp[k]));
      check(lsMem[k] == memWord(exp[k]), "R11 indexed row kept",
            lsMem[k], memWord(exp[k]));
    end
  endtask

  task automatic testPut();
    reqN = 0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) lsMem[8+k] = {8{32'hC0DE0000 + 32'(k)}};
    pushCmd(1'b0, 2'd0, 32'h20000, 6'd8, 8'd3, 4'd1, 32'h0);
    waitDone(5);
    check(reqN == 3, "R6 store count", DW'(reqN), 3);
    for (int k = 0; k < 3; k++) begin
      check(reqWr[k] == 1'b1 && reqAddr[k] == 32'h20000 + 32*k, "R6 store addr",
            DW'(reqAddr[k]), DW'(32'h20000 + 32*k));
      check(reqData[k] == {8{32'hC0DE0000 + 32'(k)}}, "R6 store data",
            reqData[k], {8{32'hC0DE0000 + 32'(k)}});
    end
  endtask

  task automatic testZero();
    reqN = 0;
    pushCmd(1'b1, 2'd0, 32'h9000, 6'd0, 8'd0, 4'd1, 32'h0);
    waitDone(6);
    check(doneN == 6, "R10 zero-count done", DW'(doneN), 6);
    check(reqN == 0, "R10 no requests", DW'(reqN), 0);
  endtask

  task automatic testQueue();
    reqN = 0;
    setFlags(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++)
      pushCmd(1'b1, 2'd0, 32'h30000 + 32'(i)*32'h40, 6'(56 + i), 8'd1, 4'd1, 32'h0);
    @(negedge clk);
    check(cmdReady == 1'b0, "R1 queue full", DW'(cmdReady), 0);
    setFlags(1'b0, 1'b0, 1'b0);
    waitDone(11);
    for (int i = 0; i < 5; i++) begin
      check(doneLog[6+i] == IDW'(6+i), "R1 done order", DW'(doneLog[6+i]), DW'(6+i));
      check(reqAddr[i] == 32'h30000 + 32'(i)*32'h40, "R1 command order",
            DW'(reqAddr[i]), DW'(32'h30000 + 32'(i)*32'h40));
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) lsMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSeqGet();
    testTagsReverse();
    testStrided();
    testIndexed();
    testPut();
    testZero();
    testQueue();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule